// File: doc/BRIEF.md
# Hardwired-Control Accumulator Processor

This block is a small single-accumulator processor whose control path contains no state machine and no control store. A cycle counter runs through six microcycle states. A decoder turns the counter value into six one-hot timing strobes. Each register transfer fires when one timing strobe and one decoded instruction line are both high.

Every instruction begins with the same three-cycle fetch. The register file is small: a program counter, a memory address register, a memory data register, an opcode register, the accumulator, a sampled input register and an output register. A word memory sits inside the block.

A surrounding environment fills the memory through a load port while reset is held, then releases reset. The program runs until it reaches a halt instruction, and only reset leaves the halted state. A second, read-only port lets the environment observe any memory word at any time.

Top module: `accm_core`

## Requirements
- R1: While the machine is not halted, exactly one timing strobe is active in every cycle. While it is halted, none is active. The strobes run in order from the first, and the counter starts again at the first strobe when an instruction ends.
- R2: Fetch reads the word addressed by the program counter and increments the program counter by one. A program that halts from address N leaves the program counter at N+1.
- R3: ADD (opcode 1), AND (opcode 2) and load (opcode 3) read the word at their address field. They then set the accumulator to the 16-bit wrapping sum, the bitwise AND, or the word itself. Each of these instructions takes 6 cycles.
- R4: Store (opcode 4) writes the accumulator into memory at its address field, leaves other words unchanged, and takes 6 cycles.
- R5: Complement (opcode 5) inverts every accumulator bit. Clear (opcode 6) zeroes the accumulator. Rotate (opcode 10) moves every accumulator bit one place toward the MSB, and the old MSB enters bit 0. Each takes 4 cycles.
- R6: Input (opcode 8) loads the accumulator from the registered value of `in_data`. Output (opcode 9) copies the accumulator to `out_data`. Each takes 4 cycles.
- R7: Jump-if-zero (opcode 7) loads the program counter with its address field only when the accumulator is zero. In both cases it takes 4 cycles.
- R8: Halt (opcode 0) raises `halted` at the end of its fourth cycle. After that, the program counter, the accumulator and `out_data` stay constant until reset, whatever `in_data` does.
- R9: Synchronous active-high reset clears the program counter, the accumulator, `out_data` and `halted`, and restarts the counter at the first strobe.
- R10: Opcodes 11 to 15 change no register except through fetch, and each takes 4 cycles.
- R11: Bits 15:12 of an instruction word are the opcode and bits 11:0 are the address field. The memory is addressed by the low MEM_AW bits of an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Value sampled into the input register every cycle |
| load_en | input | 1 | Write `load_data` into memory at `load_addr` |
| load_addr | input | MEM_AW | Memory preload address |
| load_data | input | 16 | Memory preload word |
| mon_addr | input | MEM_AW | Memory observation address |
| mon_data | output | 16 | Memory word at `mon_addr` (combinational) |
| out_data | output | 16 | Output register |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| halted | output | 1 | Machine stopped by halt |

## Verification
The bench uses the default MEM_AW of 8, which gives a 256-word memory. Every program and data word therefore sits at an address below 0x30. The memory is small enough that the bench can clear all of it through the load port before each program, so no earlier contents can leak into a later run. The bench counts the cycles from reset release until `halted` rises. This makes the 4-cycle and 6-cycle execute lengths and the counter's return to the first strobe visible at the ports. The jump-if-zero tests take the branch in one program and skip it in another.

// File: rtl/accm_pkg.sv
package accm_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int ADDR_W = WORD_W - OP_W;
    localparam int NUM_T  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_HLT = 4'd0,
        OP_ADD = 4'd1,
        OP_AND = 4'd2,
        OP_LDA = 4'd3,
        OP_STA = 4'd4,
        OP_CMA = 4'd5,
        OP_CLA = 4'd6,
        OP_JZ  = 4'd7,
        OP_IN  = 4'd8,
        OP_OUT = 4'd9,
        OP_CIL = 4'd10
    } opcode_e;

    typedef struct packed {
        logic hlt;
        logic add;
        logic bitand;
        logic lda;
        logic sta;
        logic cma;
        logic cla;
        logic jz;
        logic inp;
        logic outp;
        logic cil;
        logic mem_op;
    } ilines_t;

    function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction
endpackage

// File: rtl/accm_timing.sv
module accm_timing
    import accm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic             last,
    output logic [NUM_T-1:0] t,
    output logic             halted
);
    localparam int CNT_W = $clog2(NUM_T);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (stop) halted <= 1'b1;
            if (last || stop) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end

    for (genvar j = 0; j < NUM_T; j++) begin : g_dec
        assign t[j] = !halted && (cnt == CNT_W'(j));
    end

    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        !halted |-> $countones(t) == 1);
    assert_no_strobe_halted_R1: assert property (@(posedge clk) disable iff (rst)
        halted |-> t == '0);
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
endmodule

// File: rtl/accm_decode.sv
module accm_decode
    import accm_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ilines_t         il
);
    always_comb begin
        il = '0;
        case (op)
            OP_HLT: il.hlt    = 1'b1;
            OP_ADD: il.add    = 1'b1;
            OP_AND: il.bitand = 1'b1;
            OP_LDA: il.lda    = 1'b1;
            OP_STA: il.sta    = 1'b1;
            OP_CMA: il.cma    = 1'b1;
            OP_CLA: il.cla    = 1'b1;
            OP_JZ:  il.jz     = 1'b1;
            OP_IN:  il.inp    = 1'b1;
            OP_OUT: il.outp   = 1'b1;
            OP_CIL: il.cil    = 1'b1;
            default: il = '0;
        endcase
        il.mem_op = il.add | il.bitand | il.lda | il.sta;
    end
endmodule

// File: rtl/accm_mem.sv
module accm_mem
    import accm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic [AW-1:0]     maddr,
    output logic [WORD_W-1:0] mdata
);
    localparam int DEPTH = 2 ** AW;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
    assign mdata = store[maddr];
endmodule

// File: rtl/accm_core.sv
module accm_core
    import accm_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              load_en,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic [MEM_AW-1:0] mon_addr,
    output logic [WORD_W-1:0] mon_data,
    output logic [WORD_W-1:0] out_data,
    output logic [WORD_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted
);
    logic [NUM_T-1:0]  t;
    ilines_t           il;
    logic [MEM_AW-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [OP_W-1:0]   opc;
    logic [WORD_W-1:0] inr;
    logic [WORD_W-1:0] mem_rd;
    logic              stop, last;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;

    accm_decode u_dec (.op(opc), .il(il));

    assign stop = t[3] & il.hlt;
    assign last = t[5] | (t[3] & ~il.mem_op);

    accm_timing u_tim (
        .clk(clk), .rst(rst), .stop(stop), .last(last), .t(t), .halted(halted)
    );

    assign mem_we    = load_en | (t[5] & il.sta);
    assign mem_waddr = load_en ? load_addr : mar;
    assign mem_wdata = load_en ? load_data : mdr;

    accm_mem #(.AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mar), .rdata(mem_rd), .maddr(mon_addr), .mdata(mon_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            mar      <= '0;
            mdr      <= '0;
            opc      <= '0;
            acc      <= '0;
            inr      <= '0;
            out_data <= '0;
        end else begin
            inr <= in_data;
            // fetch
            if (t[0]) mar <= pc[MEM_AW-1:0];
            if (t[1]) begin
                mdr <= mem_rd;
                pc  <= pc + 1'b1;
            end
            if (t[2]) opc <= mdr[WORD_W-1:ADDR_W];
            // execute
            if (t[3]) begin
                if (il.mem_op) mar <= mdr[MEM_AW-1:0];
                if (il.cma)    acc <= ~acc;
                if (il.cla)    acc <= '0;
                if (il.inp)    acc <= inr;
                if (il.outp)   out_data <= acc;
                if (il.cil)    acc <= rotl1(acc);
                if (il.jz && acc == '0) pc <= mdr[ADDR_W-1:0];
            end
            if (t[4]) begin
                if (il.add || il.bitand || il.lda) mdr <= mem_rd;
                if (il.sta)                        mdr <= acc;
            end
            if (t[5]) begin
                if (il.add)    acc <= acc + mdr;
                if (il.bitand) acc <= acc & mdr;
                if (il.lda)    acc <= mdr;
            end
        end
    end

    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (rst)
        t[1] |=> pc == $past(pc) + 1'b1);
    assert_short_return_R5: assert property (@(posedge clk) disable iff (rst)
        (t[3] && !il.mem_op && !il.hlt) |=> t[0]);
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc) && $stable(acc) && $stable(out_data)));
    assert_jz_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (t[3] && il.jz && acc != '0) |=> t[0] && pc == $past(pc));
endmodule

// File: tb/accm_core_bench.sv
module accm_core_bench;
    localparam int PERIOD = 10;
    localparam int AW = 8;
    localparam int NV = 9;
    // {second instruction, word at 0x10, word at 0x11, expected acc}
    localparam logic [63:0] VEC [NV] = '{
        64'h1011_1234_0FFF_2233,
        64'h1011_FFFF_0002_0001,
        64'h2011_F0F0_3C3C_3030,
        64'h3011_1111_BEEF_BEEF,
        64'h5000_00FF_0000_FF00,
        64'h6000_ABCD_0000_0000,
        64'hA000_8001_0000_0003,
        64'hA000_4000_0000_8000,
        64'hB123_5555_0000_5555
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] in_data = '0;
    logic load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0] load_data = '0;
    logic [AW-1:0] mon_addr = '0;
    logic [15:0] mon_data, out_data, acc;
    logic [11:0] pc;
    logic halted;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    accm_core #(.MEM_AW(AW)) u_accm_core (
        .clk(clk), .rst(rst), .in_data(in_data), .load_en(load_en),
        .load_addr(load_addr), .load_data(load_data), .mon_addr(mon_addr),
        .mon_data(mon_data), .out_data(out_data), .acc(acc), .pc(pc), .halted(halted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic hold_reset_clear();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 2 ** AW; i++) put(AW'(i), 16'h0000);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 300) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] op, a, b, exp;
        int exp_cyc;

        // R9 reset state
        hold_reset_clear();
        chk("R9 pc after reset", 32'(pc), 0);
        chk("R9 acc after reset", 32'(acc), 0);
        chk("R9 out after reset", 32'(out_data), 0);
        chk("R9 halted after reset", 32'(halted), 0);

        // table: LDA 0x10 ; op ; HLT  (R3 R5 R10 R11 R1 R2)
        for (int v = 0; v < NV; v++) begin
            {op, a, b, exp} = VEC[v];
            hold_reset_clear();
            put(8'h00, 16'h3010);
            put(8'h01, op);
            put(8'h02, 16'h0000);
            put(8'h10, a);
            put(8'h11, b);
            run(cyc);
            exp_cyc = (op[15:12] >= 4'd1 && op[15:12] <= 4'd4) ? 16 : 14;
            chk($sformatf("R3/R5/R10 acc vec %0d", v), 32'(acc), 32'(exp));
            chk($sformatf("R2 pc vec %0d", v), 32'(pc), 3);
            chk($sformatf("R1 cycles vec %0d", v), cyc, exp_cyc);
        end

        // R7 jump taken: CLA; JZ 5; LDA 10; HLT; -; LDA 11; HLT
        hold_reset_clear();
        put(8'h00, 16'h6000); put(8'h01, 16'h7005); put(8'h02, 16'h3010);
        put(8'h03, 16'h0000); put(8'h05, 16'h3011); put(8'h06, 16'h0000);
        put(8'h10, 16'h1111); put(8'h11, 16'h2222);
        run(cyc);
        chk("R7 taken acc", 32'(acc), 32'h2222);
        chk("R7 taken pc", 32'(pc), 7);
        chk("R7 taken cycles", cyc, 18);

        // R7/R6 jump not taken then OUT
        hold_reset_clear();
        put(8'h00, 16'h3010); put(8'h01, 16'h7005); put(8'h02, 16'h9000);
        put(8'h03, 16'h0000); put(8'h05, 16'h6000); put(8'h10, 16'h0040);
        run(cyc);
        chk("R7 not taken out", 32'(out_data), 32'h0040);
        chk("R7 not taken pc", 32'(pc), 4);
        chk("R6 out cycles", cyc, 18);

        // R4 store
        hold_reset_clear();
        put(8'h00, 16'h3010); put(8'h01, 16'h4020); put(8'h02, 16'h0000);
        put(8'h10, 16'hCAFE);
        run(cyc);
        mon_addr = 8'h20; #1;
        chk("R4 stored word", 32'(mon_data), 32'hCAFE);
        mon_addr = 8'h21; #1;
        chk("R4 neighbour untouched", 32'(mon_data), 0);
        mon_addr = 8'h02; #1;
        chk("R4 program untouched", 32'(mon_data), 0);
        chk("R4 cycles", cyc, 16);

        // R6 input then output, R8 halt hold
        hold_reset_clear();
        in_data = 16'h7E57;
        put(8'h00, 16'h8000); put(8'h01, 16'h9000); put(8'h02, 16'h0000);
        run(cyc);
        chk("R6 in acc", 32'(acc), 32'h7E57);
        chk("R6 out", 32'(out_data), 32'h7E57);
        chk("R6 cycles", cyc, 12);
        in_data = 16'h0101;
        repeat (20) @(negedge clk);
        chk("R8 halted stays", 32'(halted), 1);
        chk("R8 pc held", 32'(pc), 3);
        chk("R8 acc held", 32'(acc), 32'h7E57);
        chk("R8 out held", 32'(out_data), 32'h7E57);

        // R9 reset from a dirty, halted state
        rst = 1'b1;
        @(negedge clk);
        chk("R9 pc cleared", 32'(pc), 0);
        chk("R9 acc cleared", 32'(acc), 0);
        chk("R9 out cleared", 32'(out_data), 0);
        chk("R9 halted cleared", 32'(halted), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule